// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs exception entry for a 32-bit in-order core with a system-control coprocessor. The pipeline raises a one-cycle request carrying an exception kind, the faulting PC, a delay-slot flag, the faulting virtual address, an address-space identifier and a coprocessor number. On the clock edge that samples the request, the block does several things at once. It updates the processor state (status, cause, exception PC, bad address, TLB entry-high, context and shadow-register-set control). It computes the handler address and drives it out together with a one-cycle flush pulse to the pipeline.

Reset puts the core at the boot vector and marks coprocessor 1 usable. A small register port lets software read every state register. Through it software sets the exception base, the boot-vector select bit, the interrupt-vector select bit, the exception shadow set, and the exception-level bit. The block does not prioritise exceptions, return from them, look up the TLB or mask interrupts.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A request with a defined kind code is taken on the rising edge that samples it. `flush` is 1 for exactly the following cycle and `redirect_pc` holds the handler address during that cycle. Every other cycle has `flush` at 0.
- R2: Every taken exception leaves the exception-level bit (status bit 0) at 1, even when it was already 1.
- R3: With `req_in_delay` at 1 the exception PC becomes `req_pc` − 4 and the delay flag (cause bit 15) becomes 1. Otherwise the exception PC is `req_pc` and the delay flag is 0.
- R4: If both exception level and boot-vector select (status bit 1) are 0 at entry, the previous set (shadow bits [11:8]) takes the current set (bits [7:4]) and the current set takes the exception set (bits [3:0]). Otherwise the shadow register is unchanged.
- R5: The cause code field (cause bits [4:0]) is written from `req_kind` as follows. Kind 0 (interrupt) gives 0. Kind 1 (TLB modify) gives 1. Kinds 2 (load refill) and 4 (load invalid) give 2. Kinds 3 (store refill) and 5 (store invalid) give 3. Kind 6 (load address error) gives 4 and kind 7 (store address error) gives 5. Kinds 8 (syscall), 9 (break), 10 (reserved instruction), 11 (coprocessor unusable), 12 (overflow) and 13 (trap) give 8, 9, 0xA, 0xB, 0xC and 0xD.
- R6: The coprocessor field (cause bits [9:8]) takes `req_cop_id` for kind 11 and is cleared for every other kind.
- R7: Kinds other than refill, interrupt and overflow under boot-vector select jump to base + 0x180. The base is the exception base register.
- R8: A refill (kinds 2, 3) jumps to base + 0x000 when exception level was 0 before entry and to base + 0x180 when it was already 1.
- R9: An interrupt jumps to base + 0x200 when the interrupt-vector bit (cause bit 12) is 1, and to base + 0x180 when it is 0.
- R10: An overflow taken with boot-vector select at 1 jumps to 0xBFC00200.
- R11: After reset, `redirect_pc` is 0xBFC00000 and `flush` is 0. Status reads 0x4 (coprocessor-1 usable at bit 2, all else 0). The exception base is `EBASE_RESET`.
- R12: Kinds 1 to 7 load the bad-address register with `req_vaddr`. Kinds 1 to 5 also load entry-high with `req_vaddr[31:13]` at bits [31:13] and `req_asid` at [7:0], and load context bits [22:4] with `req_vaddr[31:13]`. All other kinds leave these three registers unchanged.
- R13: Selects 0 to 7 read status, cause, exception PC, bad address, entry-high, context, shadow control and base. Software can write status bits 0 and 1, cause bit 12, shadow bits [3:0] and base bits [31:12]. Other bits and registers ignore writes. A write in the same cycle as a taken exception is dropped.
- R14: A request with kind 14 or 15 is ignored: no flush, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request strobe |
| req_kind | input | 4 | Exception kind code |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| req_vaddr | input | 32 | Faulting virtual address |
| req_asid | input | 8 | Address-space identifier for entry-high |
| req_cop_id | input | 2 | Coprocessor number for an unusable-coprocessor fault |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Software register select |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data for the selected register |
| flush | output | 1 | One-cycle pipeline flush pulse |
| redirect_pc | output | 32 | Handler address (boot vector after reset) |

## Verification
The bench builds the block with `EBASE_RESET` set to 0x80003000 and keeps every other parameter at its default. This non-zero base separates each vector offset from the base. A wrong offset, or an offset added twice, gives a value that cannot be mistaken for a correct one. The base is also rewritten to 0x90000000 through the software port, which shows that the vectors follow the register and not the reset value. The refill, interrupt and overflow paths are each driven with their selecting bit both set and clear.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned AW        = 32;
    localparam int unsigned ASID_W    = 8;
    localparam int unsigned SRS_W     = 4;
    localparam int unsigned COP_W     = 2;
    localparam int unsigned KIND_W    = 4;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned CODE_W    = 5;
    localparam int unsigned VPN_LSB   = 13;
    localparam int unsigned VPN_W     = AW - VPN_LSB;
    localparam int unsigned EBASE_LSB = 12;

    // software view bit positions
    localparam int unsigned STB_EXL  = 0;
    localparam int unsigned STB_BEV  = 1;
    localparam int unsigned STB_CU1  = 2;
    localparam int unsigned CSB_CODE = 0;
    localparam int unsigned CSB_CE   = 8;
    localparam int unsigned CSB_IV   = 12;
    localparam int unsigned CSB_BD   = 15;
    localparam int unsigned SSB_ESS  = 0;
    localparam int unsigned SSB_CSS  = 4;
    localparam int unsigned SSB_PSS  = 8;
    localparam int unsigned CTX_LSB  = 4;

    localparam logic [AW-1:0] OFS_GENERAL  = 'h180;
    localparam logic [AW-1:0] OFS_INTVEC   = 'h200;
    localparam logic [AW-1:0] BOOT_OVF_VEC = 32'hBFC0_0200;

    // request kinds
    localparam logic [KIND_W-1:0] K_INT     = 4'd0;
    localparam logic [KIND_W-1:0] K_TLBMOD  = 4'd1;
    localparam logic [KIND_W-1:0] K_LREFILL = 4'd2;
    localparam logic [KIND_W-1:0] K_SREFILL = 4'd3;
    localparam logic [KIND_W-1:0] K_LINVAL  = 4'd4;
    localparam logic [KIND_W-1:0] K_SINVAL  = 4'd5;
    localparam logic [KIND_W-1:0] K_ADEL    = 4'd6;
    localparam logic [KIND_W-1:0] K_ADES    = 4'd7;
    localparam logic [KIND_W-1:0] K_SYSCALL = 4'd8;
    localparam logic [KIND_W-1:0] K_BREAK   = 4'd9;
    localparam logic [KIND_W-1:0] K_RESV    = 4'd10;
    localparam logic [KIND_W-1:0] K_COPU    = 4'd11;
    localparam logic [KIND_W-1:0] K_OVF     = 4'd12;
    localparam logic [KIND_W-1:0] K_TRAP    = 4'd13;

    // software selects
    localparam logic [SEL_W-1:0] SEL_STATUS  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CAUSE   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_EPC     = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BADVA   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_ENTRYHI = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CONTEXT = 3'd5;
    localparam logic [SEL_W-1:0] SEL_SRS     = 3'd6;
    localparam logic [SEL_W-1:0] SEL_EBASE   = 3'd7;

    typedef enum logic [1:0] {
        VEC_GENERAL,
        VEC_REFILL,
        VEC_INTR,
        VEC_OVF
    } vec_class_e;

    typedef struct packed {
        logic cu1;
        logic bev;
        logic exl;
    } status_t;

    typedef struct packed {
        logic              bd;
        logic              iv;
        logic [COP_W-1:0]  ce;
        logic [CODE_W-1:0] code;
    } cause_t;

    typedef struct packed {
        logic [SRS_W-1:0] pss;
        logic [SRS_W-1:0] css;
        logic [SRS_W-1:0] ess;
    } srs_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn2;
        logic [ASID_W-1:0] asid;
    } entryhi_t;

    function automatic logic kind_legal(input logic [KIND_W-1:0] k);
        return k <= K_TRAP;
    endfunction

    function automatic logic [CODE_W-1:0] kind_code(input logic [KIND_W-1:0] k);
        case (k)
            K_TLBMOD:            return 5'd1;
            K_LREFILL, K_LINVAL: return 5'd2;
            K_SREFILL, K_SINVAL: return 5'd3;
            K_ADEL:              return 5'd4;
            K_ADES:              return 5'd5;
            K_SYSCALL:           return 5'd8;
            K_BREAK:             return 5'd9;
            K_RESV:              return 5'hA;
            K_COPU:              return 5'hB;
            K_OVF:               return 5'hC;
            K_TRAP:              return 5'hD;
            default:             return 5'd0;
        endcase
    endfunction

    function automatic logic kind_is_tlb(input logic [KIND_W-1:0] k);
        return (k >= K_TLBMOD) && (k <= K_SINVAL);
    endfunction

    function automatic logic kind_sets_badva(input logic [KIND_W-1:0] k);
        return (k >= K_TLBMOD) && (k <= K_ADES);
    endfunction

    function automatic vec_class_e kind_vec_class(input logic [KIND_W-1:0] k);
        case (k)
            K_LREFILL, K_SREFILL: return VEC_REFILL;
            K_INT:                return VEC_INTR;
            K_OVF:                return VEC_OVF;
            default:              return VEC_GENERAL;
        endcase
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
(
    input  vec_class_e         cls,
    input  logic [AW-1:0]      ebase,
    input  logic               exl_before,
    input  logic               bev,
    input  logic               iv,
    output logic [AW-1:0]      vec
);
    logic [AW-1:0] general_vec;

    assign general_vec = ebase + OFS_GENERAL;

    always_comb begin
        case (cls)
            VEC_REFILL: vec = exl_before ? general_vec : ebase;
            VEC_INTR:   vec = iv ? (ebase + OFS_INTVEC) : general_vec;
            VEC_OVF:    vec = bev ? BOOT_OVF_VEC : general_vec;
            default:    vec = general_vec;
        endcase
    end
endmodule

// File: rtl/exc_csr_view.sv
module exc_csr_view
    import exc_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             we,
    input  logic             hold,
    input  status_t          status,
    input  cause_t           cause,
    input  logic [AW-1:0]    epc,
    input  logic [AW-1:0]    badva,
    input  entryhi_t         entryhi,
    input  logic [VPN_W-1:0] ctx_vpn,
    input  srs_t             srs,
    input  logic [AW-1:0]    ebase,
    output logic [AW-1:0]    rdata,
    output logic             wr_status,
    output logic             wr_cause,
    output logic             wr_srs,
    output logic             wr_ebase
);
    logic wr_go;

    assign wr_go     = we && !hold;
    assign wr_status = wr_go && (sel == SEL_STATUS);
    assign wr_cause  = wr_go && (sel == SEL_CAUSE);
    assign wr_srs    = wr_go && (sel == SEL_SRS);
    assign wr_ebase  = wr_go && (sel == SEL_EBASE);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS: begin
                rdata[STB_EXL] = status.exl;
                rdata[STB_BEV] = status.bev;
                rdata[STB_CU1] = status.cu1;
            end
            SEL_CAUSE: begin
                rdata[CSB_CODE +: CODE_W] = cause.code;
                rdata[CSB_CE +: COP_W]    = cause.ce;
                rdata[CSB_IV]             = cause.iv;
                rdata[CSB_BD]             = cause.bd;
            end
            SEL_EPC:   rdata = epc;
            SEL_BADVA: rdata = badva;
            SEL_ENTRYHI: begin
                rdata[AW-1:VPN_LSB]  = entryhi.vpn2;
                rdata[ASID_W-1:0]    = entryhi.asid;
            end
            SEL_CONTEXT: rdata[CTX_LSB +: VPN_W] = ctx_vpn;
            SEL_SRS: begin
                rdata[SSB_ESS +: SRS_W] = srs.ess;
                rdata[SSB_CSS +: SRS_W] = srs.css;
                rdata[SSB_PSS +: SRS_W] = srs.pss;
            end
            default:   rdata = ebase;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC   = 32'hBFC0_0000,
    parameter logic [31:0] EBASE_RESET = 32'h8000_0000,
    parameter int unsigned INSN_BYTES  = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [AW-1:0]     req_pc,
    input  logic              req_in_delay,
    input  logic [AW-1:0]     req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [COP_W-1:0]  req_cop_id,
    input  logic              sw_we,
    input  logic [SEL_W-1:0]  sw_sel,
    input  logic [AW-1:0]     sw_wdata,
    output logic [AW-1:0]     sw_rdata,
    output logic              flush,
    output logic [AW-1:0]     redirect_pc
);
    localparam logic [AW-1:0] INSN_STEP = AW'(INSN_BYTES);

    status_t          status_q;
    cause_t           cause_q;
    srs_t             srs_q;
    entryhi_t         entryhi_q;
    logic [AW-1:0]    epc_q;
    logic [AW-1:0]    badva_q;
    logic [AW-1:0]    ebase_q;
    logic [VPN_W-1:0] ctx_vpn_q;

    logic             take;
    vec_class_e       cls;
    logic [AW-1:0]    vec;
    logic             wr_status, wr_cause, wr_srs, wr_ebase;
    logic             sw_unused;

    assign take      = req_valid && kind_legal(req_kind);
    assign cls       = kind_vec_class(req_kind);
    assign sw_unused = ^sw_wdata;

    exc_vector_sel u_vec (
        .cls        (cls),
        .ebase      (ebase_q),
        .exl_before (status_q.exl),
        .bev        (status_q.bev),
        .iv         (cause_q.iv),
        .vec        (vec)
    );

    exc_csr_view u_view (
        .sel       (sw_sel),
        .we        (sw_we),
        .hold      (take),
        .status    (status_q),
        .cause     (cause_q),
        .epc       (epc_q),
        .badva     (badva_q),
        .entryhi   (entryhi_q),
        .ctx_vpn   (ctx_vpn_q),
        .srs       (srs_q),
        .ebase     (ebase_q),
        .rdata     (sw_rdata),
        .wr_status (wr_status),
        .wr_cause  (wr_cause),
        .wr_srs    (wr_srs),
        .wr_ebase  (wr_ebase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q    <= '{cu1: 1'b1, bev: 1'b0, exl: 1'b0};
            cause_q     <= '0;
            srs_q       <= '0;
            entryhi_q   <= '0;
            epc_q       <= '0;
            badva_q     <= '0;
            ctx_vpn_q   <= '0;
            ebase_q     <= EBASE_RESET;
            flush       <= 1'b0;
            redirect_pc <= RESET_VEC;
        end else begin
            flush <= take;
            if (take) begin
                status_q.exl <= 1'b1;
                if (!status_q.exl && !status_q.bev) begin
                    srs_q.pss <= srs_q.css;
                    srs_q.css <= srs_q.ess;
                end
                epc_q        <= req_in_delay ? (req_pc - INSN_STEP) : req_pc;
                cause_q.bd   <= req_in_delay;
                cause_q.code <= kind_code(req_kind);
                cause_q.ce   <= (req_kind == K_COPU) ? req_cop_id : '0;
                if (kind_sets_badva(req_kind)) begin
                    badva_q <= req_vaddr;
                end
                if (kind_is_tlb(req_kind)) begin
                    entryhi_q.vpn2 <= req_vaddr[AW-1:VPN_LSB];
                    entryhi_q.asid <= req_asid;
                    ctx_vpn_q      <= req_vaddr[AW-1:VPN_LSB];
                end
                redirect_pc <= vec;
            end else begin
                if (wr_status) begin
                    status_q.exl <= sw_wdata[STB_EXL];
                    status_q.bev <= sw_wdata[STB_BEV];
                end
                if (wr_cause) begin
                    cause_q.iv <= sw_wdata[CSB_IV];
                end
                if (wr_srs) begin
                    srs_q.ess <= sw_wdata[SSB_ESS +: SRS_W];
                end
                if (wr_ebase) begin
                    ebase_q <= {sw_wdata[AW-1:EBASE_LSB], {EBASE_LSB{1'b0}}};
                end
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter int unsigned INSN_BYTES = 4
)(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [KIND_W-1:0] req_kind,
    input logic [AW-1:0]     req_pc,
    input logic              req_in_delay,
    input logic              flush,
    input logic [AW-1:0]     redirect_pc,
    input logic              exl,
    input logic              bev,
    input logic              cu1,
    input logic              bd,
    input logic [AW-1:0]     epc,
    input logic [AW-1:0]     ebase,
    input logic [3*SRS_W-1:0] srs
);
    logic acc;
    logic rst_prev;

    assign acc = req_valid && (req_kind <= K_TRAP);

    always_ff @(posedge clk) rst_prev <= rst;

    AST_FLUSH_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        acc |=> flush);                                                     // R1
    AST_NO_SPURIOUS_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !flush);                                                   // R14
    AST_EXL_SET: assert property (@(posedge clk) disable iff (rst)
        acc |=> exl);                                                       // R2
    AST_DELAY_EPC: assert property (@(posedge clk) disable iff (rst)
        (acc && req_in_delay) |=> (bd && epc == $past(req_pc) - AW'(INSN_BYTES))); // R3
    AST_SRS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc && (exl || bev)) |=> $stable(srs));                            // R4
    AST_REFILL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (acc && !exl && (req_kind == K_LREFILL || req_kind == K_SREFILL))
        |=> (redirect_pc == $past(ebase)));                                 // R8

    always @(posedge clk) begin
        if (rst_prev === 1'b1) begin
            AST_RESET_STATE: assert (redirect_pc == RESET_VEC && cu1 && !flush); // R11
        end
    end
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .RESET_VEC  (RESET_VEC),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_pc       (req_pc),
    .req_in_delay (req_in_delay),
    .flush        (flush),
    .redirect_pc  (redirect_pc),
    .exl          (status_q.exl),
    .bev          (status_q.bev),
    .cu1          (status_q.cu1),
    .bd           (cause_q.bd),
    .epc          (epc_q),
    .ebase        (ebase_q),
    .srs          (srs_q)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    import exc_pkg::*;

    localparam logic [31:0] EB = 32'h8000_3000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [KIND_W-1:0] req_kind = '0;
    logic [AW-1:0]     req_pc = '0;
    logic              req_in_delay = 1'b0;
    logic [AW-1:0]     req_vaddr = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic [COP_W-1:0]  req_cop_id = '0;
    logic              sw_we = 1'b0;
    logic [SEL_W-1:0]  sw_sel = '0;
    logic [AW-1:0]     sw_wdata = '0;
    logic [AW-1:0]     sw_rdata;
    logic              flush;
    logic [AW-1:0]     redirect_pc;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    exc_entry_ctrl #(.EBASE_RESET(EB)) u0 (
        .clk, .rst, .req_valid, .req_kind, .req_pc, .req_in_delay,
        .req_vaddr, .req_asid, .req_cop_id, .sw_we, .sw_sel, .sw_wdata,
        .sw_rdata, .flush, .redirect_pc
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [SEL_W-1:0] sel, output logic [31:0] v);
        @(negedge clk);
        sw_sel = sel;
        #1;
        v = sw_rdata;
    endtask

    task automatic wr(input logic [SEL_W-1:0] sel, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // drive one request; returns just after the edge that takes it
    task automatic fire(input logic [3:0] k, input logic [31:0] pc, input logic dly,
                        input logic [31:0] va, input logic [7:0] asid, input logic [1:0] cop);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_pc = pc; req_in_delay = dly;
        req_vaddr = va; req_asid = asid; req_cop_id = cop;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] cause_val(input logic [4:0] code, input logic [1:0] ce,
                                              input logic iv, input logic bd);
        return 32'(code) | (32'(ce) << 8) | (32'(iv) << 12) | (32'(bd) << 15);
    endfunction

    task automatic t_reset;
        check("R11 redirect after reset", redirect_pc, 32'hBFC0_0000);
        check("R11 flush after reset", 32'(flush), 32'd0);
        rd(SEL_STATUS, rv); check("R11 status after reset", rv, 32'h4);
        rd(SEL_EBASE, rv);  check("R11 base after reset", rv, EB);
    endtask

    task automatic t_syscall;
        fire(K_SYSCALL, 32'h0040_0100, 1'b0, 32'h0, 8'h0, 2'd0);
        check("R1 flush on syscall", 32'(flush), 32'd1);
        check("R7 general vector", redirect_pc, EB + 32'h180);
        @(negedge clk);
        check("R1 flush drops", 32'(flush), 32'd0);
        rd(SEL_STATUS, rv); check("R2 exl set", rv, 32'h5);
        rd(SEL_EPC, rv);    check("R3 epc plain", rv, 32'h0040_0100);
        rd(SEL_CAUSE, rv);  check("R5 syscall code, bd clear", rv, cause_val(5'd8, 2'd0, 1'b0, 1'b0));
    endtask

    task automatic t_delay;
        fire(K_BREAK, 32'h0040_0200, 1'b1, 32'h0, 8'h0, 2'd0);
        check("R7 break vector", redirect_pc, EB + 32'h180);
        rd(SEL_EPC, rv);    check("R3 epc delay slot", rv, 32'h0040_01FC);
        rd(SEL_CAUSE, rv);  check("R3 bd set", rv, cause_val(5'd9, 2'd0, 1'b0, 1'b1));
        rd(SEL_STATUS, rv); check("R2 exl stays set", rv, 32'h5);
    endtask

    task automatic t_refill;
        logic [31:0] va;
        va = 32'h1234_5678;
        wr(SEL_STATUS, 32'h0);
        fire(K_LREFILL, 32'h0040_0300, 1'b0, va, 8'h5A, 2'd0);
        check("R8 refill exl clear", redirect_pc, EB);
        rd(SEL_CAUSE, rv);   check("R5 load refill code", rv, cause_val(5'd2, 2'd0, 1'b0, 1'b0));
        rd(SEL_BADVA, rv);   check("R12 badva", rv, va);
        rd(SEL_ENTRYHI, rv); check("R12 entryhi", rv, (va & 32'hFFFF_E000) | 32'h5A);
        rd(SEL_CONTEXT, rv); check("R12 context", rv, (va >> 13) << 4);
        fire(K_SREFILL, 32'h0040_0304, 1'b0, 32'hCAFE_0000, 8'h11, 2'd0);
        check("R8 refill exl set", redirect_pc, EB + 32'h180);
        rd(SEL_CAUSE, rv);   check("R5 store refill code", rv, cause_val(5'd3, 2'd0, 1'b0, 1'b0));
        wr(SEL_STATUS, 32'h0);
        fire(K_LINVAL, 32'h0040_0308, 1'b0, 32'h0000_4000, 8'h22, 2'd0);
        check("R7 invalid uses general vector", redirect_pc, EB + 32'h180);
        fire(K_TLBMOD, 32'h0040_030C, 1'b0, 32'h0000_8000, 8'h33, 2'd0);
        rd(SEL_CAUSE, rv);   check("R5 tlb modify code", rv, cause_val(5'd1, 2'd0, 1'b0, 1'b0));
        rd(SEL_ENTRYHI, rv); check("R12 entryhi tlb modify", rv, 32'h0000_8033);
    endtask

    task automatic t_addr;
        logic [31:0] eh;
        rd(SEL_ENTRYHI, eh);
        fire(K_ADES, 32'h0040_0400, 1'b0, 32'h0000_0003, 8'h77, 2'd0);
        rd(SEL_CAUSE, rv);   check("R5 store address error code", rv, cause_val(5'd5, 2'd0, 1'b0, 1'b0));
        rd(SEL_BADVA, rv);   check("R12 badva address error", rv, 32'h0000_0003);
        rd(SEL_ENTRYHI, rv); check("R12 entryhi kept on address error", rv, eh);
        fire(K_ADEL, 32'h0040_0404, 1'b0, 32'h0000_0001, 8'h0, 2'd0);
        rd(SEL_CAUSE, rv);   check("R5 load address error code", rv, cause_val(5'd4, 2'd0, 1'b0, 1'b0));
        fire(K_RESV, 32'h0040_0408, 1'b0, 32'hFFFF_FFF0, 8'h0, 2'd0);
        rd(SEL_BADVA, rv);   check("R12 badva kept on reserved", rv, 32'h0000_0001);
        rd(SEL_CAUSE, rv);   check("R5 reserved code", rv, cause_val(5'hA, 2'd0, 1'b0, 1'b0));
    endtask

    task automatic t_intr;
        fire(K_INT, 32'h0040_0500, 1'b0, 32'h0, 8'h0, 2'd0);
        check("R9 interrupt iv clear", redirect_pc, EB + 32'h180);
        wr(SEL_CAUSE, 32'h1000);
        fire(K_INT, 32'h0040_0504, 1'b0, 32'h0, 8'h0, 2'd0);
        check("R9 interrupt iv set", redirect_pc, EB + 32'h200);
        rd(SEL_CAUSE, rv);  check("R5 interrupt code with iv", rv, cause_val(5'd0, 2'd0, 1'b1, 1'b0));
        wr(SEL_CAUSE, 32'h0);
    endtask

    task automatic t_ovf;
        wr(SEL_STATUS, 32'h2);
        fire(K_OVF, 32'h0040_0600, 1'b0, 32'h0, 8'h0, 2'd0);
        check("R10 overflow boot vector", redirect_pc, 32'hBFC0_0200);
        wr(SEL_STATUS, 32'h0);
        fire(K_OVF, 32'h0040_0604, 1'b0, 32'h0, 8'h0, 2'd0);
        check("R10 overflow normal vector", redirect_pc, EB + 32'h180);
        rd(SEL_CAUSE, rv);  check("R5 overflow code", rv, cause_val(5'hC, 2'd0, 1'b0, 1'b0));
    endtask

    task automatic t_srs;
        wr(SEL_SRS, 32'h5);
        wr(SEL_STATUS, 32'h0);
        fire(K_TRAP, 32'h0040_0700, 1'b0, 32'h0, 8'h0, 2'd0);
        rd(SEL_SRS, rv); check("R4 first swap", rv, 32'h055);
        wr(SEL_SRS, 32'h3);
        wr(SEL_STATUS, 32'h0);
        fire(K_TRAP, 32'h0040_0704, 1'b0, 32'h0, 8'h0, 2'd0);
        rd(SEL_SRS, rv); check("R4 second swap", rv, 32'h533);
        wr(SEL_SRS, 32'h7);
        fire(K_TRAP, 32'h0040_0708, 1'b0, 32'h0, 8'h0, 2'd0);
        rd(SEL_SRS, rv); check("R4 held with exl set", rv, 32'h537);
        wr(SEL_STATUS, 32'h2);
        fire(K_TRAP, 32'h0040_070C, 1'b0, 32'h0, 8'h0, 2'd0);
        rd(SEL_SRS, rv); check("R4 held with bev set", rv, 32'h537);
        wr(SEL_STATUS, 32'h0);
    endtask

    task automatic t_copu;
        fire(K_COPU, 32'h0040_0800, 1'b0, 32'h0, 8'h0, 2'd2);
        rd(SEL_CAUSE, rv);  check("R6 coprocessor id loaded", rv, cause_val(5'hB, 2'd2, 1'b0, 1'b0));
        fire(K_TRAP, 32'h0040_0804, 1'b0, 32'h0, 8'h0, 2'd3);
        rd(SEL_CAUSE, rv);  check("R6 coprocessor id cleared", rv, cause_val(5'hD, 2'd0, 1'b0, 1'b0));
    endtask

    task automatic t_illegal;
        logic [31:0] e0;
        wr(SEL_STATUS, 32'h0);
        rd(SEL_EPC, e0);
        fire(4'd14, 32'h0BAD_0000, 1'b1, 32'h0, 8'h0, 2'd0);
        check("R14 no flush on kind 14", 32'(flush), 32'd0);
        fire(4'd15, 32'h0BAD_0004, 1'b0, 32'h0, 8'h0, 2'd0);
        check("R14 no flush on kind 15", 32'(flush), 32'd0);
        rd(SEL_STATUS, rv); check("R14 exl untouched", rv, 32'h4);
        rd(SEL_EPC, rv);    check("R14 epc untouched", rv, e0);
    endtask

    task automatic t_swport;
        logic [31:0] e0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = K_SYSCALL; req_pc = 32'h0040_0900; req_in_delay = 1'b0;
        sw_we = 1'b1; sw_sel = SEL_EBASE; sw_wdata = 32'h9000_0000;
        @(negedge clk);
        req_valid = 1'b0; sw_we = 1'b0;
        check("R13 exception vector during write", redirect_pc, EB + 32'h180);
        rd(SEL_EBASE, rv); check("R13 write dropped on exception", rv, EB);
        wr(SEL_EBASE, 32'h9000_0ABC);
        rd(SEL_EBASE, rv); check("R13 base low bits forced zero", rv, 32'h9000_0000);
        fire(K_SYSCALL, 32'h0040_0904, 1'b0, 32'h0, 8'h0, 2'd0);
        check("R7 vector follows new base", redirect_pc, 32'h9000_0180);
        rd(SEL_EPC, e0);
        wr(SEL_EPC, 32'hDEAD_BEEF);
        rd(SEL_EPC, rv); check("R13 epc ignores writes", rv, e0);
        wr(SEL_STATUS, 32'hFFFF_FFF8);
        rd(SEL_STATUS, rv); check("R13 status unwritable bits", rv, 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_syscall();
        t_delay();
        t_refill();
        t_addr();
        t_intr();
        t_ovf();
        t_srs();
        t_copu();
        t_illegal();
        t_swport();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule